// File: doc/BRIEF.md
# Parallel Port FIFO DMA Requester

This block decides when an enhanced parallel port asks the host DMA controller for a transfer cycle. It watches the byte FIFO's status flags, the transfer direction and two software control bits: a DMA enable bit and a service bit. From these it drives a single request line. It tracks the active-low acknowledge, the active-low I/O read strobe and the terminal count, and decides when the request must come down.

The request drops when the FIFO can no longer move a byte. It also drops on the last byte of a transfer, after a fixed number of back-to-back cycles, and at the end of a counted transfer. After a burst has been capped, the request stays low until the acknowledge has been idle for a programmable number of clocks. An acknowledged terminal count raises the interrupt output and emits a pulse that sets the service bit in the register file. The request then stays locked off until software has seen that bit set and cleared it again. The FIFO itself, register decoding and the peripheral handshake live elsewhere. All inputs are synchronous to the block clock.

Top module: `ppdma_requester`

## Requirements
- R1: After reset, `dreq_o`, `irq_o` and `svc_set_o` are all 0.
- R2: `dreq_o` is 1 only in a cycle following a cycle in which `dma_en_i` was 1 and `svc_i` was 0. Clearing the enable or setting the service bit removes the request one clock later.
- R3: With `dir_i` = 1 (FIFO to host), the request rises one clock after `fifo_empty_i` goes 0. It falls one clock after `fifo_empty_i` is 1.
- R4: With `dir_i` = 0 (host to FIFO), the request follows `fifo_full_i` inverted, one clock later. `fifo_empty_i` has no effect in this direction.
- R5: While requesting with `fifo_one_i` = 1 (one byte left, or one free slot when `dir_i` = 0), a falling edge of `dack_ni` removes the request one clock later.
- R6: When `dack_ni` is held low with no edge, a falling edge of `ior_ni` counts as a transfer cycle. With `fifo_one_i` = 1, it removes the request one clock later.
- R7: A transfer cycle (as in R5/R6) seen with `tc_i` = 1 raises `irq_o` and a one-clock `svc_set_o` pulse one clock later, and drops the request. `tc_i` outside a transfer cycle has no effect.
- R8: After a terminal count, no request is made, even with data present, until `svc_i` has been seen at 1 and then returns to 0. `irq_o` stays 1 until that same clock, and the request may return together with its clearing.
- R9: After an empty-FIFO drop, the request returns one clock after data is present, with no other condition.
- R10: The request never spans more than `BURST_MAX` acknowledge cycles. The `BURST_MAX`-th cycle removes it one clock later.
- R11: After a capped burst, the request returns only once `dack_ni` has been high for `RECOV_CYC` consecutive clocks, counted afresh each time `dack_ni` goes low. It rises with the clock of the last idle cycle.
- R12: The burst count clears whenever the request drops, so an earlier short burst does not shorten the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dma_en_i | input | 1 | DMA enable control bit |
| svc_i | input | 1 | Service bit; 1 blocks DMA |
| dir_i | input | 1 | 1 = FIFO to host, 0 = host to FIFO |
| fifo_empty_i | input | 1 | FIFO holds no byte |
| fifo_full_i | input | 1 | FIFO has no free slot |
| fifo_one_i | input | 1 | Exactly one byte (read) or one free slot (write) remains |
| dack_ni | input | 1 | DMA acknowledge, active low |
| ior_ni | input | 1 | I/O read strobe, active low |
| tc_i | input | 1 | Terminal count from the DMA controller |
| dreq_o | output | 1 | DMA request |
| irq_o | output | 1 | Transfer-complete interrupt |
| svc_set_o | output | 1 | One-clock pulse that sets the service bit |

## Verification
The bench builds the block with `BURST_MAX` = 8 and `RECOV_CYC` = 5. This puts the burst cap, the full recovery window and its restart within a few dozen cycles. A short burst followed by a full eight-cycle burst shows that the count clears between bursts. The recovery check is timed so that one clock too early or too late is visible. The terminal-count lock is stepped through its window before software arms it, its armed state, and its release.

// File: rtl/ppdma_pkg.sv
`timescale 1ns/1ps
package ppdma_pkg;
    typedef enum logic {
        DIR_HOST_TO_FIFO = 1'b0,
        DIR_FIFO_TO_HOST = 1'b1
    } xfer_dir_e;

    typedef struct packed {
        logic ack_prev;
        logic ior_prev;
    } strobe_st_t;

    typedef struct packed {
        logic lock;
        logic armed;
        logic set_pulse;
    } tclock_st_t;

    typedef struct packed {
        logic req;
    } top_st_t;
endpackage

// File: rtl/ppdma_strobe.sv
`timescale 1ns/1ps
module ppdma_strobe
    import ppdma_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic dack_ni,
    input  logic ior_ni,
    input  logic tc_i,
    output logic xfer_stb_o,
    output logic tc_hit_o
);
    strobe_st_t st_d, st_q;
    logic ack_fall, ack_held, ior_fall;

    always_comb begin
        st_d          = st_q;
        st_d.ack_prev = dack_ni;
        st_d.ior_prev = ior_ni;

        ack_fall = st_q.ack_prev & ~dack_ni;
        // acknowledge already low last cycle: read strobe marks the cycle
        ack_held = ~st_q.ack_prev & ~dack_ni;
        ior_fall = st_q.ior_prev & ~ior_ni;

        xfer_stb_o = ack_fall | (ack_held & ior_fall);
        tc_hit_o   = xfer_stb_o & tc_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{ack_prev: 1'b1, ior_prev: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/ppdma_burst.sv
`timescale 1ns/1ps
module ppdma_burst #(
    parameter int unsigned BURST_MAX = 32,
    parameter int unsigned RECOV_CYC = 44
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic req_q_i,
    input  logic xfer_stb_i,
    input  logic dack_ni,
    output logic rest_next_o
);
    localparam int unsigned BW = $clog2(BURST_MAX + 1);
    localparam int unsigned RW = $clog2(RECOV_CYC + 1);
    localparam logic [BW-1:0] BCNT_LAST = BW'(BURST_MAX - 1);
    localparam logic [RW-1:0] RCNT_LAST = RW'(RECOV_CYC - 1);

    typedef struct packed {
        logic [BW-1:0] bcnt;
        logic          rest;
        logic [RW-1:0] rcnt;
    } burst_st_t;

    burst_st_t st_d, st_q;
    logic      burst_end;

    always_comb begin
        st_d      = st_q;
        burst_end = xfer_stb_i & req_q_i & (st_q.bcnt == BCNT_LAST);

        if (!req_q_i) begin
            st_d.bcnt = '0;
        end else if (xfer_stb_i) begin
            st_d.bcnt = st_q.bcnt + BW'(1);
        end

        if (burst_end) begin
            st_d.rest = 1'b1;
            st_d.rcnt = '0;
        end else if (st_q.rest) begin
            if (!dack_ni) begin
                st_d.rcnt = '0;
            end else if (st_q.rcnt == RCNT_LAST) begin
                st_d.rest = 1'b0;
                st_d.rcnt = '0;
            end else begin
                st_d.rcnt = st_q.rcnt + RW'(1);
            end
        end

        rest_next_o = st_d.rest;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{bcnt: '0, rest: 1'b0, rcnt: '0};
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/ppdma_tclock.sv
`timescale 1ns/1ps
module ppdma_tclock
    import ppdma_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tc_hit_i,
    input  logic svc_i,
    output logic lock_next_o,
    output logic irq_o,
    output logic svc_set_o
);
    tclock_st_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.set_pulse = tc_hit_i;
        if (tc_hit_i) begin
            st_d.lock  = 1'b1;
            st_d.armed = 1'b0;
        end else if (st_q.lock) begin
            if (svc_i) begin
                st_d.armed = 1'b1;
            end else if (st_q.armed) begin
                st_d.lock  = 1'b0;
                st_d.armed = 1'b0;
            end
        end
        lock_next_o = st_d.lock;
        irq_o       = st_q.lock;
        svc_set_o   = st_q.set_pulse;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{lock: 1'b0, armed: 1'b0, set_pulse: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/ppdma_requester.sv
`timescale 1ns/1ps
module ppdma_requester
    import ppdma_pkg::*;
#(
    parameter int unsigned BURST_MAX = 32,
    parameter int unsigned RECOV_CYC = 44
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic dma_en_i,
    input  logic svc_i,
    input  logic dir_i,
    input  logic fifo_empty_i,
    input  logic fifo_full_i,
    input  logic fifo_one_i,
    input  logic dack_ni,
    input  logic ior_ni,
    input  logic tc_i,
    output logic dreq_o,
    output logic irq_o,
    output logic svc_set_o
);
    top_st_t st_d, st_q;
    logic    xfer_stb, tc_hit, rest_next, lock_next, data_ok;

    ppdma_strobe u_strobe (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .dack_ni    (dack_ni),
        .ior_ni     (ior_ni),
        .tc_i       (tc_i),
        .xfer_stb_o (xfer_stb),
        .tc_hit_o   (tc_hit)
    );

    ppdma_burst #(
        .BURST_MAX (BURST_MAX),
        .RECOV_CYC (RECOV_CYC)
    ) u_burst (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .req_q_i     (st_q.req),
        .xfer_stb_i  (xfer_stb),
        .dack_ni     (dack_ni),
        .rest_next_o (rest_next)
    );

    ppdma_tclock u_tclock (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .tc_hit_i    (tc_hit),
        .svc_i       (svc_i),
        .lock_next_o (lock_next),
        .irq_o       (irq_o),
        .svc_set_o   (svc_set_o)
    );

    always_comb begin
        st_d = st_q;
        unique case (xfer_dir_e'(dir_i))
            DIR_FIFO_TO_HOST: data_ok = ~fifo_empty_i;
            default:          data_ok = ~fifo_full_i;
        endcase
        st_d.req = dma_en_i & ~svc_i & ~lock_next & ~rest_next & data_ok
                 & ~(xfer_stb & fifo_one_i);
        dreq_o   = st_q.req;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{req: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/ppdma_requester_chk.sv
`timescale 1ns/1ps
module ppdma_requester_chk #(
    parameter int unsigned BURST_MAX = 32
) (
    input logic clk_i,
    input logic rst_ni,
    input logic dma_en_i,
    input logic svc_i,
    input logic dir_i,
    input logic fifo_empty_i,
    input logic fifo_full_i,
    input logic fifo_one_i,
    input logic dack_ni,
    input logic ior_ni,
    input logic tc_i,
    input logic dreq_o,
    input logic irq_o,
    input logic svc_set_o
);
    localparam int unsigned CW = $clog2(BURST_MAX + 2);
    logic [CW-1:0] fall_cnt_q;
    logic          ack_prev_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            fall_cnt_q <= '0;
            ack_prev_q <= 1'b1;
        end else begin
            ack_prev_q <= dack_ni;
            if (!dreq_o) begin
                fall_cnt_q <= '0;
            end else if (ack_prev_q && !dack_ni) begin
                fall_cnt_q <= fall_cnt_q + CW'(1);
            end
        end
    end

    assert_gate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!dma_en_i || svc_i) |=> !dreq_o);

    assert_empty_drop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dir_i && fifo_empty_i) |=> !dreq_o);

    assert_full_drop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!dir_i && fifo_full_i) |=> !dreq_o);

    assert_last_byte_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dreq_o && $fell(dack_ni) && fifo_one_i) |=> !dreq_o);

    assert_demand_last_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dreq_o && !dack_ni && $past(!dack_ni) && $fell(ior_ni) && fifo_one_i) |=> !dreq_o);

    assert_tc_irq_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($fell(dack_ni) && tc_i) |=> (irq_o && svc_set_o && !dreq_o));

    assert_lock_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> !dreq_o);

    assert_burst_cap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(dreq_o && (fall_cnt_q >= CW'(BURST_MAX))));
endmodule

bind ppdma_requester ppdma_requester_chk #(.BURST_MAX(BURST_MAX)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .dma_en_i     (dma_en_i),
    .svc_i        (svc_i),
    .dir_i        (dir_i),
    .fifo_empty_i (fifo_empty_i),
    .fifo_full_i  (fifo_full_i),
    .fifo_one_i   (fifo_one_i),
    .dack_ni      (dack_ni),
    .ior_ni       (ior_ni),
    .tc_i         (tc_i),
    .dreq_o       (dreq_o),
    .irq_o        (irq_o),
    .svc_set_o    (svc_set_o)
);

// File: tb/ppdma_requester_bench.sv
`timescale 1ns/1ps
module ppdma_requester_bench;
    localparam int unsigned BURST_MAX = 8;
    localparam int unsigned RECOV_CYC = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dma_en, svc, dir, f_empty, f_full, f_one, dack_n, ior_n, tc;
    logic dreq, irq, sset;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [2:0] exp_q[$];
    string      tag_q[$];
    logic [2:0] e;
    string      tg;

    always #4 clk = ~clk;

    ppdma_requester #(
        .BURST_MAX (BURST_MAX),
        .RECOV_CYC (RECOV_CYC)
    ) u_ppdma_requester (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .dma_en_i     (dma_en),
        .svc_i        (svc),
        .dir_i        (dir),
        .fifo_empty_i (f_empty),
        .fifo_full_i  (f_full),
        .fifo_one_i   (f_one),
        .dack_ni      (dack_n),
        .ior_ni       (ior_n),
        .tc_i         (tc),
        .dreq_o       (dreq),
        .irq_o        (irq),
        .svc_set_o    (sset)
    );

    // monitor: each pushed item describes outputs after the next rising edge
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            e  = exp_q.pop_front();
            tg = tag_q.pop_front();
            checks++;
            if ({dreq, irq, sset} !== e) begin
                errors++;
                $display("FAIL %s: dreq/irq/svc_set actual=%b expected=%b", tg, {dreq, irq, sset}, e);
            end
        end
    end

    // driver: apply strobes at a falling edge, queue the expectation, advance
    task automatic step(input logic a, input logic r, input logic t,
                        input logic er, input logic ei, input logic es, input string tag);
        dack_n = a; ior_n = r; tc = t;
        exp_q.push_back({er, ei, es});
        tag_q.push_back(tag);
        @(negedge clk);
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog (all requirements): actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        dma_en = 1'b1; svc = 1'b0; dir = 1'b1; f_empty = 1'b1; f_full = 1'b0;
        f_one = 1'b0; dack_n = 1'b1; ior_n = 1'b1; tc = 1'b0;
        repeat (3) @(negedge clk);
        checks++;
        if ({dreq, irq, sset} !== 3'b000) begin
            errors++;
            $display("FAIL R1 reset state: actual=%b expected=000", {dreq, irq, sset});
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R3 read direction follows empty flag
        step(1, 1, 0, 0, 0, 0, "R3 empty holds request low");
        f_empty = 1'b0;
        step(1, 1, 0, 1, 0, 0, "R3 data present raises request");
        step(1, 1, 0, 1, 0, 0, "R3 request held");

        // R2 gating by enable and service bit
        dma_en = 1'b0;
        step(1, 1, 0, 0, 0, 0, "R2 enable cleared");
        dma_en = 1'b1;
        step(1, 1, 0, 1, 0, 0, "R2 enable restored");
        svc = 1'b1;
        step(1, 1, 0, 0, 0, 0, "R2 service bit set");
        svc = 1'b0;
        step(1, 1, 0, 1, 0, 0, "R2 service bit cleared");

        // R5 last byte on acknowledge edge, then R9 empty re-request
        f_one = 1'b1;
        step(0, 1, 0, 0, 0, 0, "R5 last byte acknowledge drops request");
        f_one = 1'b0; f_empty = 1'b1;
        step(1, 1, 0, 0, 0, 0, "R3 FIFO emptied");
        f_empty = 1'b0;
        step(1, 1, 0, 1, 0, 0, "R9 re-request on one byte");

        // R12 short burst of three, then empty drop
        for (int i = 0; i < 3; i++) begin
            step(0, 1, 0, 1, 0, 0, "R12 short burst ack low");
            step(1, 1, 0, 1, 0, 0, "R12 short burst ack high");
        end
        f_empty = 1'b1;
        step(1, 1, 0, 0, 0, 0, "R12 empty drop clears burst");
        f_empty = 1'b0;
        step(1, 1, 0, 1, 0, 0, "R9 request returns");

        // R10 full burst: BURST_MAX cycles allowed, last one drops request
        for (int i = 1; i < BURST_MAX; i++) begin
            step(0, 1, 0, 1, 0, 0, "R12 full burst continues past short count");
            step(1, 1, 0, 1, 0, 0, "R10 burst below cap");
        end
        step(0, 1, 0, 0, 0, 0, "R10 cap reached drops request");

        // R11 recovery with a restart
        step(1, 1, 0, 0, 0, 0, "R11 recovery idle 1");
        step(1, 1, 0, 0, 0, 0, "R11 recovery idle 2");
        step(0, 1, 0, 0, 0, 0, "R11 acknowledge low restarts recovery");
        for (int i = 1; i < RECOV_CYC; i++) begin
            step(1, 1, 0, 0, 0, 0, "R11 still recovering");
        end
        step(1, 1, 0, 1, 0, 0, "R11 recovery complete request returns");

        // R6 demand mode: acknowledge held low, read strobe marks cycles
        step(0, 1, 0, 1, 0, 0, "R6 first cycle by acknowledge edge");
        step(0, 0, 0, 1, 0, 0, "R6 read strobe cycle not last");
        step(0, 1, 0, 1, 0, 0, "R6 read strobe released");
        f_one = 1'b1;
        step(0, 0, 0, 0, 0, 0, "R6 last byte on read strobe drops request");
        f_one = 1'b0; f_empty = 1'b1;
        step(1, 1, 0, 0, 0, 0, "R3 empty after demand burst");

        // R7 terminal count, R8 lock release
        f_empty = 1'b0;
        step(1, 1, 0, 1, 0, 0, "R9 request after refill");
        step(1, 1, 1, 1, 0, 0, "R7 count without acknowledge ignored");
        step(0, 1, 1, 0, 1, 1, "R7 acknowledged count raises interrupt");
        step(1, 1, 0, 0, 1, 0, "R8 locked before software reacts");
        svc = 1'b1;
        step(1, 1, 0, 0, 1, 0, "R8 service bit set holds lock");
        step(1, 1, 0, 0, 1, 0, "R8 lock held while armed");
        svc = 1'b0;
        step(1, 1, 0, 1, 0, 0, "R8 service cleared releases lock");

        // R4 write direction follows full flag, empty ignored
        dir = 1'b0; f_empty = 1'b1;
        step(1, 1, 0, 1, 0, 0, "R4 write direction ignores empty");
        f_full = 1'b1;
        step(1, 1, 0, 0, 0, 0, "R4 full drops request");
        f_full = 1'b0;
        step(1, 1, 0, 1, 0, 0, "R4 space returns request");
        f_one = 1'b1;
        step(0, 1, 0, 0, 0, 0, "R5 last free slot drops request");
        f_one = 1'b0; f_full = 1'b1;
        step(1, 1, 0, 0, 0, 0, "R4 full after last slot");

        repeat (3) @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule